// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block takes decimal digits in 8421 weighting one bit per clock on a single serial line, least significant bit first, and returns the Excess-3 form of each digit on a second serial line. Every result bit appears in the same cycle as the input bit that produces it. A Mealy state machine adds the constant three bit by bit. Its state holds the position inside the four-bit word and the carry still pending from that addition.

Word boundaries come from the machine itself. After a reset, the first bit is position 0. Every group of four clocks after that is one word, and words may follow each other with no gap. There is no strobe and no parallel load. The machine does not flag codes above nine, and no carry passes from one word to the next.

States and transitions:
- `ST_P0`: start and reset state, position 0. An input of 1 moves to `ST_P1_C1`. An input of 0 moves to `ST_P1_C0`.
- `ST_P1_C0`: position 1 with no carry. An input of 1 moves to `ST_P2_C1`. An input of 0 moves to `ST_P2_C0`.
- `ST_P1_C1`: position 1 with carry. Either input moves to `ST_P2_C1`.
- `ST_P2_C0`: position 2 with no carry. Either input moves to `ST_P3_C0`.
- `ST_P2_C1`: position 2 with carry. An input of 1 moves to `ST_P3_C1`. An input of 0 moves to `ST_P3_C0`.
- `ST_P3_C0` and `ST_P3_C1`: the last position. Either input returns to `ST_P0`.

Top module: `xs3_serial_conv`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 whatever `din` is. Reset is asynchronous and may be applied in the middle of a word. The first bit after release is always treated as position 0.
- R2: Digits arrive LSB first, bit k at word position k. The four `dout` bits of a word, read the same way, form the value of the digit plus three.
- R3: `dout` depends on the current state and the current `din`. When `din` changes between clock edges, `dout` follows within the same cycle.
- R4: A word lasts exactly four clocks. After position 3 the machine returns to the start state on the same edge, so back-to-back words need no idle cycle.
- R5: The code is self-complementing. Inverting all four output bits for digit d gives the output for digit 9-d, for every d from 0 to 9.
- R6: Positions 0 and 1 add a one plus the carry. Positions 2 and 3 add only the carry. A carry out of position 3 is dropped and does not reach the next word.
- R7: The state moves only on the rising clock edge. It visits only the seven named states, in position order 0, 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial BCD input, LSB first |
| dout | output | 1 | Serial Excess-3 output, valid in the same cycle as `din` |

## Verification
The bench feeds all ten digits back to back and collects each result. From these it checks the digit-plus-three values and the complement pairing. A machine that adds at the wrong positions, or lets a carry leak into the next word, breaks these results. The bench also chooses digits whose carries run into position 3, such as 7, and digits that produce no carry at all, so that a wrong carry rule shows up as a wrong value. A reset in the middle of a word checks that framing restarts at position 0; a design that kept its position would shift every later word. Toggling `din` between edges checks that the output is combinational, so a registered output would lag by one cycle.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

    localparam int DIGIT_BITS = 4;
    localparam int POS_W      = $clog2(DIGIT_BITS);
    localparam logic [DIGIT_BITS-1:0] ADDEND = 4'b0011;

    typedef enum logic [2:0] {
        ST_P0    = 3'd0,
        ST_P1_C0 = 3'd1,
        ST_P1_C1 = 3'd2,
        ST_P2_C0 = 3'd3,
        ST_P2_C1 = 3'd4,
        ST_P3_C0 = 3'd5,
        ST_P3_C1 = 3'd6
    } xs3_state_e;

    function automatic logic [POS_W-1:0] pos_of(input xs3_state_e s);
        case (s)
            ST_P1_C0, ST_P1_C1: pos_of = POS_W'(1);
            ST_P2_C0, ST_P2_C1: pos_of = POS_W'(2);
            ST_P3_C0, ST_P3_C1: pos_of = POS_W'(3);
            default:            pos_of = POS_W'(0);
        endcase
    endfunction

    function automatic logic carry_of(input xs3_state_e s);
        case (s)
            ST_P1_C1, ST_P2_C1, ST_P3_C1: carry_of = 1'b1;
            default:                      carry_of = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xs3_next_state.sv
module xs3_next_state
    import xs3_pkg::*;
(
    input  xs3_state_e cur,
    input  logic       din,
    output xs3_state_e nxt
);
    always_comb begin
        unique case (cur)
            ST_P0:    nxt = din ? ST_P1_C1 : ST_P1_C0;
            ST_P1_C0: nxt = din ? ST_P2_C1 : ST_P2_C0;
            ST_P1_C1: nxt = ST_P2_C1;
            ST_P2_C0: nxt = ST_P3_C0;
            ST_P2_C1: nxt = din ? ST_P3_C1 : ST_P3_C0;
            ST_P3_C0: nxt = ST_P0;
            ST_P3_C1: nxt = ST_P0;
            default:  nxt = ST_P0;
        endcase
    end
endmodule

// File: rtl/xs3_output.sv
module xs3_output
    import xs3_pkg::*;
(
    input  xs3_state_e cur,
    input  logic       din,
    output logic       sum_bit
);
    logic [POS_W-1:0] pos;
    logic             cin;
    logic             add_bit;

    always_comb begin
        pos     = pos_of(cur);
        cin     = carry_of(cur);
        add_bit = ADDEND[pos];
        sum_bit = din ^ add_bit ^ cin;
    end
endmodule

// File: rtl/xs3_serial_conv.sv
module xs3_serial_conv
    import xs3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    xs3_state_e state;
    xs3_state_e state_nxt;
    logic       sum_bit;

    xs3_next_state u_ns (
        .cur (state),
        .din (din),
        .nxt (state_nxt)
    );

    xs3_output u_ol (
        .cur     (state),
        .din     (din),
        .sum_bit (sum_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_P0;
        else        state <= state_nxt;
    end

    always_comb begin
        dout = rst_n ? sum_bit : 1'b0;
    end

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_P0, ST_P1_C0, ST_P1_C1, ST_P2_C0, ST_P2_C1, ST_P3_C0, ST_P3_C1}); // R7
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_P1_C0, ST_P1_C1}) |=> (state inside {ST_P2_C0, ST_P2_C1})); // R7
    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_P3_C0, ST_P3_C1}) |=> (state == ST_P0)); // R4
    AST_P0_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_P0) |-> (dout != din)); // R2
    AST_CARRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_P0 && din) |=> (state == ST_P1_C1)); // R6
    AST_CARRY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_P2_C0) |=> (state == ST_P3_C0)); // R6

endmodule

// File: tb/tb_xs3_serial_conv.sv
module tb_xs3_serial_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic dout;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic [3:0] res [10];

    xs3_serial_conv dut (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout));

    always #5 clk = ~clk;

    function automatic logic [3:0] exp_xs3(input int d);
        return 4'(d + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [3:0] d, output logic [3:0] q);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            din = d[i];
            #1 q[i] = dout;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] q;
        void'($urandom(32'h5EED_0042));
        // R1: reset holds output low
        din = 1'b1;
        #3 chk(dout == 1'b0, "R1 reset quiet", dout, 0);
        din = 1'b0;
        #1 chk(dout == 1'b0, "R1 reset quiet din0", dout, 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: same-cycle response in position 0, digit 5
        @(negedge clk);
        din = 1'b0;
        #1 chk(dout == 1'b1, "R3 din0 at pos0", dout, 1);
        #1 din = 1'b1;
        #1 chk(dout == 1'b0, "R3 din1 at pos0", dout, 0);
        q[0] = dout;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            din = 4'd5 >> i;
            #1 q[i] = dout;
        end
        chk(q == exp_xs3(5), "R3 word after toggle", q, exp_xs3(5));

        // R2 R4: all digits back to back; R7 sweep reaches every state
        for (int d = 0; d < 10; d++) begin
            send_word(4'(d), res[d]);
        end
        for (int d = 0; d < 10; d++) begin
            chk(res[d] == exp_xs3(d), "R2 R4 sweep", res[d], exp_xs3(d));
        end

        // R5: self-complement pairing
        for (int d = 0; d < 10; d++) begin
            chk((~res[d]) == res[9-d], "R5 complement", ~res[d], res[9-d]);
        end

        // R6: carry paths (7 carries into pos3, 0 none, 1 carry from pos1)
        send_word(4'd7, q);
        chk(q == 4'd10, "R6 digit7", q, 10);
        send_word(4'd0, q);
        chk(q == 4'd3, "R6 digit0 after carry word", q, 3);
        send_word(4'd1, q);
        chk(q == 4'd4, "R6 digit1", q, 4);

        // R1: mid-word reset restarts framing
        @(negedge clk); din = 1'b1;
        @(negedge clk); din = 1'b0;
        #2 rst_n = 1'b0;
        din = 1'b1;
        #1 chk(dout == 1'b0, "R1 mid-word reset quiet", dout, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        send_word(4'd6, q);
        chk(q == exp_xs3(6), "R1 framing after reset", q, exp_xs3(6));

        // R2 R4: random back-to-back digits
        for (int n = 0; n < 60; n++) begin
            int d;
            d = int'($urandom % 10);
            send_word(4'(d), q);
            chk(q == exp_xs3(d), "R2 R4 random", q, exp_xs3(d));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule